// File: doc/BRIEF.md
# Sine-Table Pulse-Width Modulator

This block turns a stored sine period into a single-bit pulse train whose high time per carrier period follows the sine. An external RC low-pass filter then recovers the analog waveform. A free-running binary counter, clocked by the fast modulator clock, is compared against a duty register. The output is high while the counter is below the duty value, so the carrier frequency is the modulator clock divided by 2^CNT_W.

The duty register is not written by a host. A sample strobe, generated outside the block, advances a table index and reloads the duty register from a built-in 100-point, 5-bit sine table. The strobe has no fixed phase relation to the counter wrap. With the strobe at 100 kHz, one pass through the table gives a 1 kHz sine after filtering. The counter width sets the carrier rate and the resolution. An enable input freezes the modulator and parks the output low.

The reset input is asynchronous and active low. Its release is synchronized to the clock through two flops.

Top module: `pwm_sine_dac`

## Requirements
- R1: While enabled and out of reset, `pwm_o` is 1 exactly when the counter value is strictly less than the duty register, and 0 otherwise. The counter's top value therefore always gives 0.
- R2: On every enabled clock edge the counter goes up by one. It wraps from 2^CNT_W-1 to 0, and `cnt_o` shows it.
- R3: The table entry at index i is 16 + round(15*sin(2*pi*i/100)), so every entry lies in 1..31. The duty register holds that entry shifted left by CNT_W-5. Over any 2^CNT_W consecutive enabled cycles at a fixed index, `pwm_o` is high for entry<<(CNT_W-5) cycles.
- R4: An enabled `tick_i` moves the index up by one, wrapping from 99 to 0. `idx_o` shows the index, which never exceeds 99.
- R5: On the same edge that advances the index, the duty register loads the entry for the new index. The counter keeps its count and is not restarted, so `pwm_o` uses the new entry from the next cycle on.
- R6: While `rst_ni` is low, the counter reads 0, the index reads 0 and the duty register holds midscale 16<<(CNT_W-5), and this takes effect without a clock. After `rst_ni` rises, the block stays in reset for two more rising edges and starts counting on the third.
- R7: While `en_i` is 0, `pwm_o` is 0, the counter and the index hold, and `tick_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Run enable; low parks output and freezes state |
| tick_i | input | 1 | Sample strobe advancing the sine index |
| pwm_o | output | 1 | Pulse-width-modulated output bit |
| idx_o | output | 7 | Current sine table index (0..99) |
| cnt_o | output | CNT_W | Current carrier counter value |

## Verification
The bench walks the index through all 100 table points and past the 99-to-0 wrap. After each strobe it counts the high cycles over one full carrier period and compares the count with a sine value computed in floating point. This separates a wrong table entry, an off-by-one compare (≤ instead of <) and a duty register that lags the index. The strobes arrive at a counter phase that changes from point to point, which shows that a strobe neither restarts the carrier nor loses a count. Separate phases pulse the strobe while the block is disabled, assert reset asynchronously in the middle of a run, and count the cycles of reset-release latency.

// File: rtl/pwm_sine_pkg.sv
package pwm_sine_pkg;
  localparam int SAMP_W   = 5;
  localparam int TBL_LEN  = 100;
  localparam int IDX_W    = $clog2(TBL_LEN);
  localparam int QTR      = TBL_LEN / 4;
  localparam int SAMP_MID = 16;

  // Magnitude of 15*sin over the first quarter period, rounded; k = 0..25
  function automatic logic [3:0] quarter_mag(input logic [4:0] k);
    logic [3:0] m;
    case (k)
      5'd0:  m = 4'd0;
      5'd1:  m = 4'd1;
      5'd2:  m = 4'd2;
      5'd3:  m = 4'd3;
      5'd4:  m = 4'd4;
      5'd5:  m = 4'd5;
      5'd6:  m = 4'd6;
      5'd7:  m = 4'd6;
      5'd8:  m = 4'd7;
      5'd9:  m = 4'd8;
      5'd10: m = 4'd9;
      5'd11: m = 4'd10;
      5'd12: m = 4'd10;
      5'd13: m = 4'd11;
      5'd14: m = 4'd12;
      5'd15: m = 4'd12;
      5'd16: m = 4'd13;
      5'd17: m = 4'd13;
      5'd18: m = 4'd14;
      5'd19: m = 4'd14;
      5'd20: m = 4'd14;
      default: m = 4'd15;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pwm_sine_rst_sync.sv
module pwm_sine_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/pwm_sine_counter.sv
module pwm_sine_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_sine_table.sv
module pwm_sine_table
  import pwm_sine_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SAMP_W-1:0] samp_o
);
  localparam logic [IDX_W-1:0] Q1 = IDX_W'(QTR);
  localparam logic [IDX_W-1:0] Q2 = IDX_W'(2 * QTR);
  localparam logic [IDX_W-1:0] Q3 = IDX_W'(3 * QTR);
  localparam logic [IDX_W-1:0] Q4 = IDX_W'(TBL_LEN);

  logic [IDX_W-1:0] k;
  logic             neg;
  logic [3:0]       mag;

  // Fold the index into the first quarter and pick the sign
  always_comb begin
    if (idx_i <= Q1) begin
      k = idx_i;       neg = 1'b0;
    end else if (idx_i <= Q2) begin
      k = Q2 - idx_i;  neg = 1'b0;
    end else if (idx_i <= Q3) begin
      k = idx_i - Q2;  neg = 1'b1;
    end else begin
      k = Q4 - idx_i;  neg = 1'b1;
    end
    mag = quarter_mag(k[4:0]);
    if (neg) samp_o = SAMP_W'(SAMP_MID) - SAMP_W'(mag);
    else     samp_o = SAMP_W'(SAMP_MID) + SAMP_W'(mag);
  end
endmodule

// File: rtl/pwm_sine_seq.sv
module pwm_sine_seq
  import pwm_sine_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam int SHIFT = CNT_W - SAMP_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TBL_LEN - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  duty_q, duty_d;
  logic [SAMP_W-1:0] samp_nxt;
  logic [CNT_W-1:0]  duty_nxt;
  logic [CNT_W-1:0]  duty_mid;
  logic              adv;

  pwm_sine_table u_table (
    .idx_i  (idx_d),
    .samp_o (samp_nxt)
  );

  generate
    if (SHIFT == 0) begin : g_noshift
      assign duty_nxt = samp_nxt;
      assign duty_mid = CNT_W'(SAMP_MID);
    end else begin : g_shift
      assign duty_nxt = {samp_nxt, {SHIFT{1'b0}}};
      assign duty_mid = {SAMP_W'(SAMP_MID), {SHIFT{1'b0}}};
    end
  endgenerate

  assign adv = en_i & tick_i;

  always_comb begin
    idx_d = idx_q;
    if (adv) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_comb begin
    duty_d = duty_q;
    if (adv) duty_d = duty_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      duty_q <= duty_mid;
    end else begin
      idx_q  <= idx_d;
      duty_q <= duty_d;
    end
  end

  assign idx_o  = idx_q;
  assign duty_o = duty_q;

  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
  p_idx_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && idx_q == LAST) |=> idx_q == '0);
  p_idx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(idx_q) && $stable(duty_q)));
  p_duty_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q >> SHIFT) >= CNT_W'(1) && (duty_q >> SHIFT) <= CNT_W'(31));
endmodule

// File: rtl/pwm_sine_dac.sv
module pwm_sine_dac
  import pwm_sine_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic             pwm_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty;

  pwm_sine_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  pwm_sine_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en_i),
    .cnt_o  (cnt)
  );

  pwm_sine_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en_i),
    .tick_i (tick_i),
    .idx_o  (idx_o),
    .duty_o (duty)
  );

  assign pwm_o = en_i & (cnt < duty);
  assign cnt_o = cnt;

  p_pwm_top_low_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cnt_o == {CNT_W{1'b1}}) |-> !pwm_o);
  p_pwm_zero_high_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (en_i && cnt_o == '0) |-> pwm_o);
endmodule

// File: tb/pwm_sine_dac_bench.sv
module pwm_sine_dac_bench;
  localparam int CW  = 5;
  localparam int TOP = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n, en, tick;
  logic          pwm;
  logic [6:0]    idx;
  logic [CW-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int tbl [100];
  int m_cnt, m_idx, m_hold;
  bit m_rst;

  always #5 clk = ~clk;

  pwm_sine_dac #(.CNT_W(CW)) u_pwm_sine_dac (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .tick_i (tick),
    .pwm_o (pwm), .idx_o (idx), .cnt_o (cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pwm(input bit e);
    return (e && m_cnt < tbl[m_idx]) ? 1 : 0;
  endfunction

  // One clock: drive, advance model after the edge, check at negedge
  task automatic step(input bit e, input bit t, input string tag);
    en = e; tick = t;
    @(posedge clk);
    #1;
    if (!m_rst) begin
      if (m_hold > 0) m_hold--;
      else if (e) begin
        m_cnt = (m_cnt + 1) % TOP;
        if (t) m_idx = (m_idx == 99) ? 0 : m_idx + 1;
      end
    end
    @(negedge clk);
    check({tag, " R2 cnt"}, int'(cnt), m_cnt);
    check({tag, " R4 idx"}, int'(idx), m_idx);
    check({tag, " R1 pwm"}, int'(pwm), exp_pwm(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100; i++) begin
      real a;
      a = 15.0 * $sin(2.0 * 3.14159265358979 * i / 100.0);
      tbl[i] = 16 + ((a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5));
    end
    rst_n = 1'b0; en = 1'b0; tick = 1'b0;
    m_rst = 1'b1; m_cnt = 0; m_idx = 0; m_hold = 0;

    // R6: reset state
    repeat (3) step(1'b0, 1'b0, "R6 reset");
    step(1'b1, 1'b1, "R6 reset en");
    check("R6 pwm midscale in reset", int'(pwm), 1);

    // R6: release latency of two edges
    rst_n = 1'b1; m_rst = 1'b0; m_hold = 2;
    step(1'b1, 1'b0, "R6 release1");
    step(1'b1, 1'b0, "R6 release2");
    check("R6 held through sync", int'(cnt), 0);
    step(1'b1, 1'b0, "R6 first count");
    check("R6 counting starts", int'(cnt), 1);

    // R3/R4/R5: sweep every table point plus wrap, strobe at shifting phase
    for (int s = 0; s < 102; s++) begin
      int highs;
      step(1'b1, 1'b1, "R5 tick");
      highs = 0;
      for (int c = 0; c < TOP; c++) begin
        step(1'b1, 1'b0, "R3 carrier");
        highs += int'(pwm);
      end
      check($sformatf("R3 highs idx %0d", m_idx), highs, tbl[m_idx]);
      if (m_idx == 0) check("R4 wrap to 0", int'(idx), 0);
      for (int x = 0; x < (s % 7); x++) step(1'b1, 1'b0, "R5 phase");
    end

    // R7: disabled, strobes ignored
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, "R7 disabled");
    check("R7 pwm low", int'(pwm), 0);
    for (int k = 0; k < 40; k++) step(1'b1, (k % 9) == 0, "R7 resume");

    // R6: asynchronous reset mid-run
    @(posedge clk); #2;
    rst_n = 1'b0; m_rst = 1'b1; m_cnt = 0; m_idx = 0;
    #1;
    check("R6 async cnt", int'(cnt), 0);
    check("R6 async idx", int'(idx), 0);
    @(negedge clk);
    step(1'b1, 1'b1, "R6 held");
    rst_n = 1'b1; m_rst = 1'b0; m_hold = 2;
    for (int k = 0; k < 70; k++) step(1'b1, (k % 11) == 3, "R6 rerun");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule